// File: doc/BRIEF.md
# Split Translation Lookaside Buffer with Range Purge

This block caches virtual-to-physical page translations in two independent halves: one serves instruction fetch, the other serves data access. Each half has a small set of pinned slots that software fills by explicit index, and a small set of cache slots that are filled in rotation. A single command port carries four operations. Each operation names the half it acts on: pinned insert, cache insert, pinned purge and cache purge.

Insert and purge work on address ranges. Each entry covers a naturally aligned power-of-two byte range, and a purge also names such a range. Any valid entry whose range intersects the purge range, and whose region identifier matches, is removed. The region identifier comes from a bank of eight region identifiers, picked by the top three bits of the command address. Every command finishes in a fixed two cycles. It ends with a one-cycle done pulse and a count of the entries it invalidated. A lookup made in any cycle after the done pulse sees the updated contents. A combinational lookup port takes a side, a region identifier and a virtual address, and returns hit and physical page number.

Top module: `split_tlb`

## Requirements
- R1: After reset, every entry is invalid, every lookup misses, `cmd_done` is low and `cmd_killed` is zero.
- R2: A command with `cmd_valid` high is accepted at a clock edge only while the block is idle. `cmd_done` is high for exactly the one cycle after the second edge. A command presented while the block is busy has no effect.
- R3: A lookup hits a valid entry when the side matches, the region identifier matches, and the address lies in the entry's aligned 2^size byte range. It returns that entry's page number. A pinned hit wins over a cache hit, and among equal kinds the lowest slot wins.
- R4: Command op 0 (pinned insert) writes the slot named by `cmd_slot`, overwriting any entry already there. It also invalidates every overlapping cache entry on both sides, and `cmd_killed` reports how many.
- R5: Command op 1 (cache insert) fills the cache slots of its side in rotation starting at slot 0, wrapping after the last. It invalidates nothing and reports zero.
- R6: Command op 2 (pinned purge) removes every overlapping pinned entry on its own side, whichever slot holds it. It also removes overlapping cache entries on both sides. Pinned entries on the other side are never touched. `cmd_killed` reports the total removed.
- R7: Command op 3 (cache purge) removes only the overlapping cache entries of the named side.
- R8: An inserted entry takes its region identifier from the region register selected by bits [VA_W-1:VA_W-3] of its address. A purge matches only entries whose region identifier equals the one selected by the purge address, whatever the range size.
- R9: The range size is log2 of the byte count, taken from `cmd_arg[7:2]`, and `cmd_arg[1:0]` is ignored. Two ranges overlap when their addresses agree above the larger of the two sizes.
- R10: The same translation may sit in a pinned slot of each side at once. Both copies hit independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_ids | input | 8*RID_W | Eight region identifiers; identifier k in bits [k*RID_W +: RID_W] |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 pinned insert, 1 cache insert, 2 pinned purge, 3 cache purge |
| cmd_side | input | 1 | 0 instruction side, 1 data side |
| cmd_slot | input | $clog2(NPIN) | Pinned slot for op 0 |
| cmd_va | input | VA_W | Virtual address of the range |
| cmd_arg | input | 8 | Size field in bits 7:2 |
| cmd_ppn | input | PPN_W | Physical page number for inserts |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_killed | output | CNT_W | Entries invalidated by the last command |
| lk_side | input | 1 | Lookup side |
| lk_rid | input | RID_W | Lookup region identifier |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page of the hit |

## Verification
The bench targets cross-side effects. A pinned insert must clear the other side's cache entries: a design that cleared only its own side would leave a stale data hit, and it would report one kill too few. A pinned purge on one side must leave the other side's identical pinned copy in place. A design that ignored the side would lose the instruction copy, and the later lookup would miss. Region mismatch is tested with a full-address-space purge that must remove nothing. Ignored low size bits are tested with a purge whose bits 1:0 are set. A command driven during the busy cycle is tested: a design that accepted it would show an unexpected hit.

// File: rtl/split_tlb.sv
module split_tlb #(
  parameter int VA_W   = 32,
  parameter int PPN_W  = 20,
  parameter int RID_W  = 8,
  parameter int NPIN   = 4,
  parameter int NCACHE = 4,
  parameter int CNT_W  = $clog2(2 * (NPIN + NCACHE) + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [8*RID_W-1:0]   region_ids,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic                 cmd_side,
  input  logic [$clog2(NPIN)-1:0] cmd_slot,
  input  logic [VA_W-1:0]      cmd_va,
  input  logic [7:0]           cmd_arg,
  input  logic [PPN_W-1:0]     cmd_ppn,
  output logic                 cmd_done,
  output logic [CNT_W-1:0]     cmd_killed,
  input  logic                 lk_side,
  input  logic [RID_W-1:0]     lk_rid,
  input  logic [VA_W-1:0]      lk_va,
  output logic                 lk_hit,
  output logic [PPN_W-1:0]     lk_ppn
);
  localparam int SLOT_W = $clog2(NPIN);
  localparam int RR_W   = $clog2(NCACHE);
  localparam logic [1:0] OP_INS_PIN = 2'd0, OP_INS_C = 2'd1, OP_PRG_PIN = 2'd2, OP_PRG_C = 2'd3;

  function automatic logic overlap(input logic [VA_W-1:0] a, input logic [5:0] sa,
                                   input logic [VA_W-1:0] b, input logic [5:0] sb);
    logic [5:0] m;
    logic [VA_W-1:0] mask;
    m = (sa > sb) ? sa : sb;
    mask = (int'(m) >= VA_W) ? '0 : ({VA_W{1'b1}} << m);
    return ((a ^ b) & mask) == '0;
  endfunction

  logic [1:0][NPIN-1:0]   pv;
  logic [1:0][NCACHE-1:0] cv;
  logic [RID_W-1:0] prid [2][NPIN];
  logic [VA_W-1:0]  pva  [2][NPIN];
  logic [5:0]       psz  [2][NPIN];
  logic [PPN_W-1:0] pppn [2][NPIN];
  logic [RID_W-1:0] crid [2][NCACHE];
  logic [VA_W-1:0]  cva  [2][NCACHE];
  logic [5:0]       csz  [2][NCACHE];
  logic [PPN_W-1:0] cppn [2][NCACHE];
  logic [RR_W-1:0]  rr   [2];

  logic              busy;
  logic [1:0]        q_op;
  logic              q_side;
  logic [SLOT_W-1:0] q_slot;
  logic [VA_W-1:0]   q_va;
  logic [5:0]        q_sz;
  logic [PPN_W-1:0]  q_ppn;
  logic [RID_W-1:0]  q_rid;

  wire accept = cmd_valid && !busy;
  wire [RID_W-1:0] cmd_rid = region_ids[cmd_va[VA_W-1 -: 3]*RID_W +: RID_W];

  logic [1:0][NPIN-1:0]   pkill;
  logic [1:0][NCACHE-1:0] ckill;
  logic pin_left, cache_left;

  always_comb begin
    pkill = '0;
    ckill = '0;
    pin_left = 1'b0;
    cache_left = 1'b0;
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < NPIN; i++) begin
        if (pv[s][i] && prid[s][i] == q_rid && overlap(pva[s][i], psz[s][i], q_va, q_sz)) begin
          if (s == int'(q_side)) begin
            pin_left = 1'b1;
            if (q_op == OP_PRG_PIN) pkill[s][i] = 1'b1;
          end
        end
      end
      for (int i = 0; i < NCACHE; i++) begin
        if (cv[s][i] && crid[s][i] == q_rid && overlap(cva[s][i], csz[s][i], q_va, q_sz)) begin
          cache_left = 1'b1;
          if (q_op == OP_INS_PIN || q_op == OP_PRG_PIN || (q_op == OP_PRG_C && s == int'(q_side)))
            ckill[s][i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cmd_done <= 1'b0;
      cmd_killed <= '0;
      pv <= '0;
      cv <= '0;
      rr[0] <= '0;
      rr[1] <= '0;
      q_op <= '0;
      q_side <= 1'b0;
      q_slot <= '0;
      q_va <= '0;
      q_sz <= '0;
      q_ppn <= '0;
      q_rid <= '0;
    end else begin
      cmd_done <= busy;
      if (accept) begin
        busy   <= 1'b1;
        q_op   <= cmd_op;
        q_side <= cmd_side;
        q_slot <= cmd_slot;
        q_va   <= cmd_va;
        q_sz   <= cmd_arg[7:2];
        q_ppn  <= cmd_ppn;
        q_rid  <= cmd_rid;
      end
      if (busy) begin
        busy <= 1'b0;
        cmd_killed <= CNT_W'($countones(pkill) + $countones(ckill));
        pv <= pv & ~pkill;
        cv <= cv & ~ckill;
        if (q_op == OP_INS_PIN) begin
          pv[q_side][q_slot]   <= 1'b1;
          prid[q_side][q_slot] <= q_rid;
          pva[q_side][q_slot]  <= q_va;
          psz[q_side][q_slot]  <= q_sz;
          pppn[q_side][q_slot] <= q_ppn;
        end else if (q_op == OP_INS_C) begin
          cv[q_side][rr[q_side]]   <= 1'b1;
          crid[q_side][rr[q_side]] <= q_rid;
          cva[q_side][rr[q_side]]  <= q_va;
          csz[q_side][rr[q_side]]  <= q_sz;
          cppn[q_side][rr[q_side]] <= q_ppn;
          rr[q_side] <= (rr[q_side] == RR_W'(NCACHE - 1)) ? '0 : rr[q_side] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int i = NCACHE - 1; i >= 0; i--)
      if (cv[lk_side][i] && crid[lk_side][i] == lk_rid && overlap(cva[lk_side][i], csz[lk_side][i], lk_va, 6'd0)) begin
        lk_hit = 1'b1;
        lk_ppn = cppn[lk_side][i];
      end
    for (int i = NPIN - 1; i >= 0; i--)
      if (pv[lk_side][i] && prid[lk_side][i] == lk_rid && overlap(pva[lk_side][i], psz[lk_side][i], lk_va, 6'd0)) begin
        lk_hit = 1'b1;
        lk_ppn = pppn[lk_side][i];
      end
  end

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 cmd_done);

  // R4
  pin_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && q_op == OP_INS_PIN |-> pv[q_side][q_slot] && pppn[q_side][q_slot] == q_ppn);

  // R4
  cache_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && q_op == OP_INS_PIN |-> !cache_left);

  // R6
  purge_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && q_op == OP_PRG_PIN |-> !pin_left && !cache_left);

  // R6
  other_pin_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && q_op == OP_PRG_PIN |-> $stable(pv[~q_side]));

  // R7
  other_cache_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && q_op == OP_PRG_C |-> $stable(cv[~q_side]) && $stable(pv));
endmodule

// File: tb/split_tlb_test.sv
module split_tlb_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [63:0] region_ids = {8'h17, 8'h16, 8'h15, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        cmd_side;
  logic [1:0]  cmd_slot;
  logic [31:0] cmd_va;
  logic [7:0]  cmd_arg;
  logic [19:0] cmd_ppn;
  logic        cmd_done;
  logic [4:0]  cmd_killed;
  logic        lk_side;
  logic [7:0]  lk_rid;
  logic [31:0] lk_va;
  logic        lk_hit;
  logic [19:0] lk_ppn;

  split_tlb uut (
    .clk(clk), .rst_n(rst_n), .region_ids(region_ids),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_side(cmd_side), .cmd_slot(cmd_slot),
    .cmd_va(cmd_va), .cmd_arg(cmd_arg), .cmd_ppn(cmd_ppn),
    .cmd_done(cmd_done), .cmd_killed(cmd_killed),
    .lk_side(lk_side), .lk_rid(lk_rid), .lk_va(lk_va), .lk_hit(lk_hit), .lk_ppn(lk_ppn)
  );

  int n_chk = 0;
  int n_bad = 0;

  // op side slot va arg ppn expected_kills
  localparam logic [69:0] VEC [15] = '{
    {2'd1, 1'b0, 2'd0, 32'h0000_1000, 8'h30, 20'h00111, 5'd0},  // R5
    {2'd1, 1'b1, 2'd0, 32'h0000_1000, 8'h30, 20'h00222, 5'd0},  // R5
    {2'd1, 1'b0, 2'd0, 32'h0000_5000, 8'h30, 20'h00333, 5'd0},  // R5
    {2'd0, 1'b0, 2'd1, 32'h0000_0000, 8'h40, 20'h00444, 5'd3},  // R4 both sides
    {2'd1, 1'b0, 2'd0, 32'h0002_0000, 8'h30, 20'h00555, 5'd0},  // R5
    {2'd0, 1'b1, 2'd0, 32'h0000_0000, 8'h40, 20'h00666, 5'd0},  // R10
    {2'd3, 1'b0, 2'd0, 32'h0002_0abc, 8'h30, 20'h00000, 5'd1},  // R7 R9
    {2'd1, 1'b1, 2'd0, 32'h0003_0000, 8'h30, 20'h00777, 5'd0},  // R5
    {2'd1, 1'b0, 2'd0, 32'h0003_0000, 8'h30, 20'h00888, 5'd0},  // R5
    {2'd3, 1'b1, 2'd0, 32'h0003_0000, 8'h30, 20'h00000, 5'd1},  // R7 named side only
    {2'd2, 1'b1, 2'd0, 32'h0000_8000, 8'h30, 20'h00000, 5'd1},  // R6
    {2'd2, 1'b0, 2'd0, 32'h0003_0000, 8'h30, 20'h00000, 5'd1},  // R6 cache part
    {2'd1, 1'b1, 2'd0, 32'h2000_4000, 8'h30, 20'h00999, 5'd0},  // R8
    {2'd3, 1'b1, 2'd0, 32'h0000_4000, 8'h80, 20'h00000, 5'd0},  // R8 rid mismatch
    {2'd3, 1'b1, 2'd0, 32'h2000_4000, 8'h33, 20'h00000, 5'd1}   // R9 low bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic side, input logic [1:0] slot,
                        input logic [31:0] va, input logic [7:0] arg, input logic [19:0] ppn,
                        input logic [4:0] exp_k, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_side = side; cmd_slot = slot;
    cmd_va = va; cmd_arg = arg; cmd_ppn = ppn;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " R2 done low while busy"}, {31'd0, cmd_done}, 32'd0);
    @(negedge clk);
    check({req, " R2 done pulse"}, {31'd0, cmd_done}, 32'd1);
    check({req, " kill count"}, {27'd0, cmd_killed}, {27'd0, exp_k});
  endtask

  task automatic look(input logic side, input logic [7:0] rid, input logic [31:0] va,
                      input logic hit, input logic [19:0] ppn, input string req);
    lk_side = side; lk_rid = rid; lk_va = va;
    #1;
    check({req, " hit"}, {31'd0, lk_hit}, {31'd0, hit});
    if (hit) check({req, " ppn"}, {12'd0, lk_ppn}, {12'd0, ppn});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_side = 1'b0; cmd_slot = '0;
    cmd_va = '0; cmd_arg = '0; cmd_ppn = '0; lk_side = 1'b0; lk_rid = '0; lk_va = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done", {31'd0, cmd_done}, 32'd0);
    check("R1 killed", {27'd0, cmd_killed}, 32'd0);
    look(1'b0, 8'h10, 32'h0, 1'b0, '0, "R1 i miss");
    look(1'b1, 8'h10, 32'h0, 1'b0, '0, "R1 d miss");

    for (int k = 0; k < 15; k++) begin
      do_cmd(VEC[k][69:68], VEC[k][67], VEC[k][66:65], VEC[k][64:33], VEC[k][32:25],
             VEC[k][24:5], VEC[k][4:0], $sformatf("vec%0d", k));
    end

    look(1'b0, 8'h10, 32'h0000_abcd, 1'b1, 20'h00444, "R6 other side pinned kept, R3");
    look(1'b1, 8'h10, 32'h0000_abcd, 1'b0, '0, "R6 data pinned purged");
    look(1'b1, 8'h10, 32'h0000_1000, 1'b0, '0, "R4 data cache killed");
    look(1'b0, 8'h11, 32'h0000_abcd, 1'b0, '0, "R3 rid mismatch");

    do_cmd(2'd1, 1'b0, 2'd0, 32'h0000_2000, 8'h30, 20'h00AAA, 5'd0, "R5 wrap");
    look(1'b0, 8'h10, 32'h0000_2abc, 1'b1, 20'h00444, "R3 pinned priority");
    do_cmd(2'd0, 1'b0, 2'd1, 32'h0010_0000, 8'h30, 20'h00BBB, 5'd0, "R4 overwrite");
    look(1'b0, 8'h10, 32'h0000_2abc, 1'b1, 20'h00AAA, "R4 old pinned gone");
    look(1'b0, 8'h10, 32'h0010_0fff, 1'b1, 20'h00BBB, "R4 new pinned");
    look(1'b0, 8'h10, 32'h0010_1000, 1'b0, '0, "R3 range edge");

    do_cmd(2'd1, 1'b1, 2'd0, 32'h0040_0000, 8'h30, 20'h00D01, 5'd0, "R5 d");
    do_cmd(2'd1, 1'b0, 2'd0, 32'h0040_0000, 8'h30, 20'h00C01, 5'd0, "R5 i");
    do_cmd(2'd0, 1'b0, 2'd2, 32'h0040_0000, 8'h30, 20'h00CCC, 5'd2, "R4 cross side");
    do_cmd(2'd0, 1'b1, 2'd3, 32'h0040_0000, 8'h30, 20'h00DDD, 5'd0, "R10");
    look(1'b0, 8'h10, 32'h0040_0010, 1'b1, 20'h00CCC, "R10 i copy");
    look(1'b1, 8'h10, 32'h0040_0010, 1'b1, 20'h00DDD, "R10 d copy");

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_side = 1'b1; cmd_va = 32'h0090_0000; cmd_arg = 8'h30;
    @(negedge clk);
    cmd_op = 2'd1; cmd_side = 1'b0; cmd_va = 32'h0080_0000; cmd_ppn = 20'h00EEE;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 busy cmd done", {31'd0, cmd_done}, 32'd1);
    @(negedge clk);
    check("R2 single pulse", {31'd0, cmd_done}, 32'd0);
    look(1'b0, 8'h10, 32'h0080_0000, 1'b0, '0, "R2 busy cmd ignored");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule